// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block decides, once per clock, whether one of a small set of pending interrupt sources may interrupt the core. It also produces everything the core needs to enter the handler. A source is eligible when it is requesting and the current mask level is not above that source's priority level. The mask level is a 3-bit field of the status word. The priority level is programmable per source, except for sources that are built with a fixed level.

When sources compete, the one with the lowest source number wins. The others keep requesting and are considered again once the entry in progress has finished. On acceptance the block registers four results:
- the address of the vector-table slot to fetch;
- the raised mask level;
- the updated status word;
- a one-cycle accept pulse, with a one-hot grant that tells the winning source to drop its request.

The block then presents two stack-save beats: the program counter first, then the status word as it was before the update. It stays busy until the core acknowledges the entry. Stack writes, the vector fetch and instruction execution happen outside the block.

Top module: `irq_accept_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, take_pulse, take_grant, push_valid and entry_busy are all 0.
- R2: A requesting source is accepted only if the mask level in status_in bits 14:12 is less than or equal to its priority level. A source whose level is below the mask is never accepted.
- R3: On acceptance new_mask equals the old mask plus one, saturating at 7. new_status equals status_in with bits 14:12 replaced by new_mask and all other bits unchanged.
- R4: vec_addr equals 0x6FB8 plus four times the source's vector index. The indices are 5 for source 0 (vertical blank), 7 to 10 for sources 1 to 4 (timers 0 to 3) and 12 for source 5 (serial receive).
- R5: Source 0 always uses the fixed priority level 4. Its field in src_level is ignored.
- R6: When several sources are eligible in the same cycle, only the lowest-numbered one is granted (take_grant is one-hot, bit n = source n). The others are granted in later entries.
- R7: take_pulse is high for exactly one cycle per entry, registered one clock after the accepting edge. take_grant is zero whenever take_pulse is low.
- R8: During the take_pulse cycle push_valid=1, push_is_status=0 and push_data holds pc_in. In the next cycle push_valid=1, push_is_status=1 and push_data holds the pre-entry status word, zero-extended. After that push_valid is 0.
- R9: entry_busy is high from the take_pulse cycle until the cycle after core_ack is seen in the wait phase that follows both push beats. core_ack during the push beats is ignored. No new entry starts while busy.
- R10: With no source requesting, no entry starts and the outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_in | input | 16 | Current status word; bits 14:12 hold the mask level |
| pc_in | input | 32 | Current program counter, captured on acceptance |
| src_req | input | 6 | Pending request per source, held by the source until granted |
| src_level | input | 18 | Programmed 3-bit priority per source, source n in bits 3n+2:3n |
| core_ack | input | 1 | Core has finished the entry; ends the busy state |
| take_pulse | output | 1 | One-cycle accept pulse |
| take_grant | output | 6 | One-hot winning source, valid with take_pulse |
| vec_addr | output | 24 | Vector-table address to fetch |
| new_mask | output | 3 | Mask level to load into the status word |
| new_status | output | 16 | Status word with the mask field updated |
| push_valid | output | 1 | A stack-save beat is presented |
| push_is_status | output | 1 | 0: beat carries the program counter; 1: beat carries the status word |
| push_data | output | 32 | Data of the current save beat |
| entry_busy | output | 1 | An entry is in progress |

## Verification
The hardest situation to reach from the ports is a competition in which the lowest-numbered requester is held off by the mask while a higher-numbered one is eligible. The intended winner then differs from both the lowest requester and the highest. The stimulus sets the mask between the two sources' levels. It then raises several requests together and walks them through back-to-back entries, keeping the losers asserted throughout the busy window. This shows that they are neither granted early nor lost. A second hard case is an acknowledge that arrives during the push beats. The bench holds core_ack high from before acceptance and checks that busy still spans both beats and the wait phase.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_PUSH_PC  = 2'd1,
    PH_PUSH_SR  = 2'd2,
    PH_WAIT_ACK = 2'd3
  } phase_e;

  // Raise the mask by one step, staying at the top level once reached.
  function automatic lvl_t mask_step(input lvl_t cur);
    return (cur == LVL_TOP) ? cur : lvl_t'(cur + 1'b1);
  endfunction

endpackage

// File: rtl/irq_eligible.sv
module irq_eligible
  import irq_accept_pkg::*;
#(
  parameter int                      N_SRC     = 6,
  parameter logic [N_SRC-1:0]        FIXED_EN  = 6'b000001,
  parameter logic [N_SRC*LVL_W-1:0]  FIXED_LVL = 18'd4
) (
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC*LVL_W-1:0] level,
  input  lvl_t                   mask,
  output logic [N_SRC-1:0]       elig
);

  // One comparator per source; a source with a fixed level ignores its field.
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    lvl_t eff_lvl;
    if (FIXED_EN[i]) begin : g_fixed
      assign eff_lvl = FIXED_LVL[i*LVL_W +: LVL_W];
    end else begin : g_prog
      assign eff_lvl = level[i*LVL_W +: LVL_W];
    end
    assign elig[i] = req[i] && (mask <= eff_lvl);
  end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N_SRC = 6,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] elig,
  output logic [N_SRC-1:0] onehot,
  output logic [SEL_W-1:0] sel,
  output logic             any
);

  // Isolate the lowest set bit.
  assign onehot = elig & (~elig + 1'b1);
  assign any    = |elig;

  always_comb begin
    sel = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) sel = SEL_W'(i);
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_accept_pkg::*;
#(
  parameter int                  N_SRC       = 6,
  parameter int                  SR_W        = 16,
  parameter int                  PC_W        = 32,
  parameter int                  ADDR_W      = 24,
  parameter int                  IDX_W       = 8,
  parameter int                  MASK_LSB    = 12,
  parameter int                  VEC_SHIFT   = 2,
  parameter logic [ADDR_W-1:0]   VEC_BASE    = 24'h006FB8,
  parameter logic [N_SRC*IDX_W-1:0] SRC_VEC_IDX = {8'd12, 8'd10, 8'd9, 8'd8, 8'd7, 8'd5},
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any,
  input  logic [N_SRC-1:0]  onehot,
  input  logic [SEL_W-1:0]  sel,
  input  logic [SR_W-1:0]   status_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              core_ack,
  output logic              take_pulse,
  output logic [N_SRC-1:0]  take_grant,
  output logic [ADDR_W-1:0] vec_addr,
  output lvl_t              new_mask,
  output logic [SR_W-1:0]   new_status,
  output logic              push_valid,
  output logic              push_is_status,
  output logic [PC_W-1:0]   push_data,
  output logic              entry_busy
);

  phase_e          phase;
  logic [SR_W-1:0] sr_saved;
  lvl_t            cur_mask;
  lvl_t            next_mask;
  logic [IDX_W-1:0] win_idx;
  logic [ADDR_W-1:0] win_addr;
  logic [SR_W-1:0] upd_status;

  assign cur_mask  = status_in[MASK_LSB +: LVL_W];
  assign next_mask = mask_step(cur_mask);
  assign win_idx   = SRC_VEC_IDX[sel*IDX_W +: IDX_W];
  assign win_addr  = VEC_BASE + (ADDR_W'(win_idx) << VEC_SHIFT);

  always_comb begin
    upd_status = status_in;
    upd_status[MASK_LSB +: LVL_W] = next_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase          <= PH_IDLE;
      take_pulse     <= 1'b0;
      take_grant     <= '0;
      vec_addr       <= '0;
      new_mask       <= '0;
      new_status     <= '0;
      sr_saved       <= '0;
      push_valid     <= 1'b0;
      push_is_status <= 1'b0;
      push_data      <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (any) begin
            phase          <= PH_PUSH_PC;
            take_pulse     <= 1'b1;
            take_grant     <= onehot;
            vec_addr       <= win_addr;
            new_mask       <= next_mask;
            new_status     <= upd_status;
            sr_saved       <= status_in;
            push_valid     <= 1'b1;
            push_is_status <= 1'b0;
            push_data      <= pc_in;
          end
        end
        PH_PUSH_PC: begin
          phase          <= PH_PUSH_SR;
          take_pulse     <= 1'b0;
          take_grant     <= '0;
          push_is_status <= 1'b1;
          push_data      <= PC_W'(sr_saved);
        end
        PH_PUSH_SR: begin
          phase          <= PH_WAIT_ACK;
          push_valid     <= 1'b0;
          push_is_status <= 1'b0;
          push_data      <= '0;
        end
        default: begin
          if (core_ack) phase <= PH_IDLE;
        end
      endcase
    end
  end

  assign entry_busy = (phase != PH_IDLE);

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int                     N_SRC       = 6,
  parameter int                     SR_W        = 16,
  parameter int                     PC_W        = 32,
  parameter int                     ADDR_W      = 24,
  parameter int                     IDX_W       = 8,
  parameter int                     MASK_LSB    = 12,
  parameter int                     VEC_SHIFT   = 2,
  parameter logic [ADDR_W-1:0]      VEC_BASE    = 24'h006FB8,
  parameter logic [N_SRC*IDX_W-1:0] SRC_VEC_IDX = {8'd12, 8'd10, 8'd9, 8'd8, 8'd7, 8'd5},
  parameter logic [N_SRC-1:0]       FIXED_EN    = 6'b000001,
  parameter logic [N_SRC*LVL_W-1:0] FIXED_LVL   = 18'd4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SR_W-1:0]        status_in,
  input  logic [PC_W-1:0]        pc_in,
  input  logic [N_SRC-1:0]       src_req,
  input  logic [N_SRC*LVL_W-1:0] src_level,
  input  logic                   core_ack,
  output logic                   take_pulse,
  output logic [N_SRC-1:0]       take_grant,
  output logic [ADDR_W-1:0]      vec_addr,
  output logic [LVL_W-1:0]       new_mask,
  output logic [SR_W-1:0]        new_status,
  output logic                   push_valid,
  output logic                   push_is_status,
  output logic [PC_W-1:0]        push_data,
  output logic                   entry_busy
);

  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] onehot;
  logic [SEL_W-1:0] sel;
  logic             any;

  irq_eligible #(
    .N_SRC    (N_SRC),
    .FIXED_EN (FIXED_EN),
    .FIXED_LVL(FIXED_LVL)
  ) u_elig (
    .req  (src_req),
    .level(src_level),
    .mask (status_in[MASK_LSB +: LVL_W]),
    .elig (elig)
  );

  irq_lowest_pick #(.N_SRC(N_SRC)) u_pick (
    .elig  (elig),
    .onehot(onehot),
    .sel   (sel),
    .any   (any)
  );

  irq_entry_seq #(
    .N_SRC      (N_SRC),
    .SR_W       (SR_W),
    .PC_W       (PC_W),
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .MASK_LSB   (MASK_LSB),
    .VEC_SHIFT  (VEC_SHIFT),
    .VEC_BASE   (VEC_BASE),
    .SRC_VEC_IDX(SRC_VEC_IDX)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .any           (any),
    .onehot        (onehot),
    .sel           (sel),
    .status_in     (status_in),
    .pc_in         (pc_in),
    .core_ack      (core_ack),
    .take_pulse    (take_pulse),
    .take_grant    (take_grant),
    .vec_addr      (vec_addr),
    .new_mask      (new_mask),
    .new_status    (new_status),
    .push_valid    (push_valid),
    .push_is_status(push_is_status),
    .push_data     (push_data),
    .entry_busy    (entry_busy)
  );

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int N_SRC    = 6,
  parameter int SR_W     = 16,
  parameter int ADDR_W   = 24,
  parameter int MASK_LSB = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [SR_W-1:0]   status_in,
  input logic              take_pulse,
  input logic [N_SRC-1:0]  take_grant,
  input logic [2:0]        new_mask,
  input logic              push_valid,
  input logic              push_is_status,
  input logic              entry_busy
);

  // R7: the accept pulse never lasts two cycles
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    take_pulse |=> !take_pulse);

  // R7: no grant outside the pulse
  p_grant_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !take_pulse |-> (take_grant == '0));

  // R6: exactly one source wins
  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    take_pulse |-> ($countones(take_grant) == 1));

  // R3: raised mask follows the mask seen at the accepting edge
  p_mask_step_r3: assert property (@(posedge clk) disable iff (rst)
    take_pulse |-> (new_mask == (($past(status_in[MASK_LSB +: 3]) == 3'd7)
                                 ? 3'd7 : $past(status_in[MASK_LSB +: 3]) + 3'd1)));

  // R8: program counter beat first, status beat next
  p_push_order_r8: assert property (@(posedge clk) disable iff (rst)
    take_pulse |-> (push_valid && !push_is_status) ##1 (push_valid && push_is_status));

  // R9: an entry only starts from the idle state
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
    take_pulse |-> (entry_busy && !$past(entry_busy)));

endmodule

bind irq_accept_unit irq_accept_chk #(
  .N_SRC   (N_SRC),
  .SR_W    (SR_W),
  .ADDR_W  (ADDR_W),
  .MASK_LSB(MASK_LSB)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .status_in     (status_in),
  .take_pulse    (take_pulse),
  .take_grant    (take_grant),
  .new_mask      (new_mask),
  .push_valid    (push_valid),
  .push_is_status(push_is_status),
  .entry_busy    (entry_busy)
);

// File: tb/tb_irq_accept_unit.sv
module tb_irq_accept_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] status_in;
  logic [31:0] pc_in;
  logic [5:0]  src_req;
  logic [17:0] src_level;
  logic        core_ack;
  logic        take_pulse;
  logic [5:0]  take_grant;
  logic [23:0] vec_addr;
  logic [2:0]  new_mask;
  logic [15:0] new_status;
  logic        push_valid;
  logic        push_is_status;
  logic [31:0] push_data;
  logic        entry_busy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_accept_unit dut (
    .clk(clk), .rst(rst), .status_in(status_in), .pc_in(pc_in),
    .src_req(src_req), .src_level(src_level), .core_ack(core_ack),
    .take_pulse(take_pulse), .take_grant(take_grant), .vec_addr(vec_addr),
    .new_mask(new_mask), .new_status(new_status), .push_valid(push_valid),
    .push_is_status(push_is_status), .push_data(push_data), .entry_busy(entry_busy)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_vec(input int s);
    int idx;
    case (s)
      0: idx = 5;
      5: idx = 12;
      default: idx = 6 + s;
    endcase
    return 24'h6FB8 + 24'(4 * idx);
  endfunction

  task automatic set_lvl(input int s, input logic [2:0] l);
    src_level[s*3 +: 3] = l;
  endtask

  task automatic set_mask(input logic [2:0] m);
    status_in[14:12] = m;
  endtask

  // Full entry for source s; inputs already driven at a negedge.
  task automatic run_entry(input int s, input string rq);
    logic [15:0] sr;
    logic [31:0] pc;
    logic [2:0]  m;
    logic [2:0]  nm;
    sr = status_in;
    pc = pc_in;
    m  = sr[14:12];
    nm = (m == 3'd7) ? 3'd7 : m + 3'd1;
    @(posedge clk); @(negedge clk);
    chk(rq, "take_pulse", 32'(take_pulse), 32'd1);
    chk(rq, "grant", 32'(take_grant), 32'(6'b1 << s));
    chk("R4", "vec_addr", 32'(vec_addr), 32'(exp_vec(s)));
    chk("R3", "new_mask", 32'(new_mask), 32'(nm));
    chk("R3", "new_status", 32'(new_status), 32'({sr[15], nm, sr[11:0]}));
    chk("R8", "beat0", {29'd0, push_valid, push_is_status, 1'b0}, 32'b100);
    chk("R8", "pc_data", push_data, pc);
    chk("R9", "busy_take", 32'(entry_busy), 32'd1);
    src_req[s] = 1'b0;
    @(negedge clk);
    chk("R7", "pulse_gone", 32'(take_pulse), 32'd0);
    chk("R8", "beat1", {29'd0, push_valid, push_is_status, 1'b0}, 32'b110);
    chk("R8", "sr_data", push_data, {16'd0, sr});
    @(negedge clk);
    chk("R8", "no_beat", 32'(push_valid), 32'd0);
    chk("R9", "busy_wait", 32'(entry_busy), 32'd1);
    chk("R9", "no_take_busy", 32'(take_pulse), 32'd0);
    core_ack = 1'b1;
    @(negedge clk);
    core_ack = 1'b0;
    chk("R9", "busy_released", 32'(entry_busy), 32'd0);
  endtask

  task automatic expect_quiet(input int n, input string rq);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(rq, "no_take", 32'(take_pulse), 32'd0);
      chk(rq, "not_busy", 32'(entry_busy), 32'd0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "take_rst", 32'(take_pulse), 32'd0);
    chk("R1", "grant_rst", 32'(take_grant), 32'd0);
    chk("R1", "push_rst", 32'(push_valid), 32'd0);
    chk("R1", "busy_rst", 32'(entry_busy), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy_after", 32'(entry_busy), 32'd0);
    chk("R10", "idle_no_req", 32'(take_pulse), 32'd0);
  endtask

  task automatic t_basic;
    status_in = 16'hA5C3; set_mask(3'd2); pc_in = 32'h0012_3456;
    set_lvl(1, 3'd5); src_req[1] = 1'b1;
    run_entry(1, "R2");
    status_in = 16'h0F0F; set_mask(3'd3); pc_in = 32'hDEAD_BEEF;
    set_lvl(5, 3'd3); src_req[5] = 1'b1;
    run_entry(5, "R2");
  endtask

  task automatic t_reject;
    set_mask(3'd5); set_lvl(2, 3'd4); src_req[2] = 1'b1;
    expect_quiet(4, "R2");
    set_mask(3'd4);
    run_entry(2, "R2");
  endtask

  task automatic t_saturate;
    status_in = 16'hFFFF; pc_in = 32'h8000_0001;
    set_lvl(4, 3'd7); src_req[4] = 1'b1;
    run_entry(4, "R3");
  endtask

  task automatic t_fixed;
    status_in = 16'h1234; set_mask(3'd5); pc_in = 32'h0000_0100;
    set_lvl(0, 3'd7); src_req[0] = 1'b1;
    expect_quiet(3, "R5");
    set_mask(3'd4); set_lvl(0, 3'd0);
    run_entry(0, "R5");
  endtask

  task automatic t_compete;
    status_in = 16'h0000; set_mask(3'd1); pc_in = 32'h0000_2000;
    set_lvl(1, 3'd6); set_lvl(3, 3'd6); set_lvl(5, 3'd6);
    src_req = 6'b101010;
    run_entry(1, "R6");
    run_entry(3, "R6");
    run_entry(5, "R6");
    set_mask(3'd2); set_lvl(1, 3'd1); set_lvl(3, 3'd6); set_lvl(4, 3'd7);
    src_req = 6'b011010;
    run_entry(3, "R6");
    run_entry(4, "R6");
    src_req[1] = 1'b0;
    expect_quiet(2, "R10");
  endtask

  task automatic t_early_ack;
    set_mask(3'd0); set_lvl(2, 3'd3); src_req[2] = 1'b1;
    core_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9", "early_take", 32'(take_pulse), 32'd1);
    src_req[2] = 1'b0;
    @(negedge clk);
    chk("R9", "ack_ignored_beat", 32'(entry_busy), 32'd1);
    @(negedge clk);
    chk("R9", "ack_ignored_wait", 32'(entry_busy), 32'd1);
    @(negedge clk);
    chk("R9", "ack_taken", 32'(entry_busy), 32'd0);
    core_ack = 1'b0;
  endtask

  initial begin
    rst = 1'b1; status_in = '0; pc_in = '0; src_req = '0;
    src_level = '0; core_ack = 1'b0;
    t_reset();
    t_basic();
    t_reject();
    t_saturate();
    t_fixed();
    t_compete();
    t_early_ack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule